// File: doc/BRIEF.md
# Video-Mode Line Packet Sequencer

This block walks one display frame line by line and produces, in transmission order, the descriptors of the short and blanking packets that a serial display link needs in video mode. Each descriptor carries a 6-bit data type, the 2-bit virtual channel and a 16-bit payload length. A downstream packetizer turns each descriptor into a real packet. It adds the header checksum and the payload. Lane striping and the physical layer are handled elsewhere.

A frame starts when `en` is high while the block is idle. The vertical tracker then moves through up to four regions in fixed order: sync lines, back-porch lines, active lines and front-porch lines. Any region whose count is zero is skipped. Within a line, a step walker picks the packets the configuration enables, in fixed order. The descriptors leave through a valid/ready port. After the last descriptor of the frame is accepted, `frame_done` pulses for one cycle and the block waits for `en` again. All configuration inputs must stay stable while a frame runs, and `cfg_vact` must be at least 1.

Top module: `dsivs_seq`

## Requirements
- R1: After reset, `pkt_valid` and `frame_done` are low. While `en` is low, no descriptor is presented.
- R2: A frame emits `cfg_vsa` sync lines, then `cfg_vbp` back-porch lines, then `cfg_vact` active lines, then `cfg_vfp` front-porch lines. A region with a count of zero contributes no lines.
- R3: Every line opens with one short packet of length 0. This packet has data type 0x01 on the first sync line and 0x11 on the first line that follows the last sync line. Every other line opens with 0x21.
- R4: A line outside the active region carries only its opening packet, then the end-of-transmission packet. When `cfg_vb_hse` is 1, a packet of data type 0x31 with length 0 is inserted directly after the opening packet in these lines.
- R5: An active line contains, in this order: the opening packet, the sync-width blank and a 0x31 packet, the back-porch blank, the pixel packet, the null packet, the front-porch blank, and end of transmission. The sync-width blank and the 0x31 packet appear only in sync-pulse mode (`cfg_mode` = 2). The pixel packet has data type `cfg_pix_dt` and length `cfg_act_len`. Blank packets have data type 0x19 and lengths `cfg_hsa_len`, `cfg_hbp_len` and `cfg_hfp_len`.
- R6: `cfg_hsa_off`, `cfg_hbp_off` and `cfg_hfp_off` each remove their own blank packet from active lines. They leave every other packet in place.
- R7: Mode encoding: 0 = non-burst with sync events, 1 = burst with sync events, 2 = non-burst with sync pulses, 3 = burst. In modes 0 and 2, the null packet is emitted when `cfg_null_len` is nonzero; it has data type 0x09 and length `cfg_null_len`. In modes 1 and 3, no null packet is emitted.
- R8: Each line ends with an end-of-transmission packet of data type 0x08 and length 0, unless `cfg_eot_off` is 1.
- R9: When `cfg_auto_vert` is 1, no sync or back-porch lines are emitted. The frame consists of the active lines followed by the front-porch lines.
- R10: Every descriptor carries `cfg_vc` on `pkt_vc`.
- R11: While `pkt_valid` is high and `pkt_ready` is low, the descriptor is held unchanged. No descriptor is dropped or repeated.
- R12: `frame_done` is high for exactly one cycle: the cycle after the last descriptor of the frame is accepted. `pkt_valid` is low at that point, and the block stays idle until `en` is seen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Start a frame when idle |
| cfg_vc | input | 2 | Virtual channel |
| cfg_mode | input | 2 | Video timing mode |
| cfg_auto_vert | input | 1 | Skip sync and back-porch lines |
| cfg_vb_hse | input | 1 | Add sync-end packet in non-active lines |
| cfg_hsa_off | input | 1 | Drop sync-width blank |
| cfg_hbp_off | input | 1 | Drop back-porch blank |
| cfg_hfp_off | input | 1 | Drop front-porch blank |
| cfg_eot_off | input | 1 | Drop end-of-transmission packet |
| cfg_vsa | input | LINE_W | Sync line count |
| cfg_vbp | input | LINE_W | Back-porch line count |
| cfg_vact | input | LINE_W | Active line count |
| cfg_vfp | input | LINE_W | Front-porch line count |
| cfg_hsa_len | input | LEN_W | Sync-width blank length |
| cfg_hbp_len | input | LEN_W | Back-porch blank length |
| cfg_hfp_len | input | LEN_W | Front-porch blank length |
| cfg_act_len | input | LEN_W | Pixel packet length |
| cfg_null_len | input | LEN_W | Null packet length |
| cfg_pix_dt | input | 6 | Pixel packet data type |
| pkt_ready | input | 1 | Downstream accepts descriptor |
| pkt_valid | output | 1 | Descriptor present |
| pkt_dt | output | 6 | Descriptor data type |
| pkt_vc | output | 2 | Descriptor virtual channel |
| pkt_len | output | LEN_W | Descriptor payload length |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two events can fall on the same clock edge: the acceptance of the last descriptor of a line, and the vertical tracker's region change. At that edge the tracker also decides whether the next line opens with 0x11, and whether the frame ends and `frame_done` is raised. A pseudo-random `pkt_ready` pattern, plus one forced long stall, makes these acceptances land after holds of varying length. The sweep covers sync and back-porch counts of zero and nonzero. Each accepted descriptor is compared in order with a sequence the bench builds from the line counts and flags. The frame-end pulse must appear exactly when the sequence is used up.

// File: rtl/dsivs_pkg.sv
package dsivs_pkg;
    typedef enum logic [1:0] {
        RG_VSYNC  = 2'd0,
        RG_VBACK  = 2'd1,
        RG_VACT   = 2'd2,
        RG_VFRONT = 2'd3
    } region_e;

    // step order inside a line is the emission order
    typedef enum logic [3:0] {
        ST_START   = 4'd0,
        ST_BLK_HSE = 4'd1,
        ST_HSA     = 4'd2,
        ST_HSE     = 4'd3,
        ST_HBP     = 4'd4,
        ST_PIX     = 4'd5,
        ST_NULL    = 4'd6,
        ST_HFP     = 4'd7,
        ST_EOT     = 4'd8
    } step_e;

    localparam int NUM_STEPS   = 9;
    localparam int NUM_REGIONS = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_SEND = 2'd2
    } phase_e;

    localparam logic [1:0] MD_NB_EVENT = 2'd0;
    localparam logic [1:0] MD_B_EVENT  = 2'd1;
    localparam logic [1:0] MD_NB_PULSE = 2'd2;
    localparam logic [1:0] MD_BURST    = 2'd3;

    localparam logic [5:0] DT_VSS   = 6'h01;
    localparam logic [5:0] DT_VSE   = 6'h11;
    localparam logic [5:0] DT_HSS   = 6'h21;
    localparam logic [5:0] DT_HSE   = 6'h31;
    localparam logic [5:0] DT_BLANK = 6'h19;
    localparam logic [5:0] DT_NULL  = 6'h09;
    localparam logic [5:0] DT_EOT   = 6'h08;
endpackage

// File: rtl/dsivs_vert.sv
module dsivs_vert
    import dsivs_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_adv,
    input  logic              cfg_auto_vert,
    input  logic [LINE_W-1:0] cfg_vsa,
    input  logic [LINE_W-1:0] cfg_vbp,
    input  logic [LINE_W-1:0] cfg_vact,
    input  logic [LINE_W-1:0] cfg_vfp,
    output region_e           region,
    output logic              first_vs_line,
    output logic              vse_line,
    output logic              last_line
);
    typedef struct packed {
        region_e           rg;
        logic [LINE_W-1:0] cnt;
        logic              vse;
    } vstate_t;

    vstate_t q, d;

    logic [LINE_W-1:0]      cnt_of [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] present;

    assign cnt_of[0] = cfg_vsa;
    assign cnt_of[1] = cfg_vbp;
    assign cnt_of[2] = cfg_vact;
    assign cnt_of[3] = cfg_vfp;

    genvar g;
    generate
        for (g = 0; g < NUM_REGIONS; g++) begin : g_present
            if (g < 2) begin : g_skippable
                assign present[g] = (cnt_of[g] != '0) && !cfg_auto_vert;
            end else begin : g_fixed
                assign present[g] = (cnt_of[g] != '0);
            end
        end
    endgenerate

    logic    nxt_found, fst_found;
    region_e nxt_rg, fst_rg;
    logic    end_of_region;

    always_comb begin
        nxt_found = 1'b0;
        nxt_rg    = RG_VFRONT;
        fst_found = 1'b0;
        fst_rg    = RG_VACT;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (!nxt_found && (i > int'(q.rg)) && present[i]) begin
                nxt_found = 1'b1;
                nxt_rg    = region_e'(2'(i));
            end
            if (!fst_found && present[i]) begin
                fst_found = 1'b1;
                fst_rg    = region_e'(2'(i));
            end
        end
    end

    assign end_of_region = ({1'b0, q.cnt} + 1'b1) == {1'b0, cnt_of[q.rg]};

    always_comb begin
        d = q;
        if (frame_start) begin
            d.rg  = fst_rg;
            d.cnt = '0;
            d.vse = 1'b0;
        end else if (line_adv) begin
            if (end_of_region) begin
                d.rg  = nxt_rg;
                d.cnt = '0;
                d.vse = (q.rg == RG_VSYNC);
            end else begin
                d.cnt = q.cnt + 1'b1;
                d.vse = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{rg: RG_VACT, cnt: '0, vse: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign region        = q.rg;
    assign first_vs_line = (q.rg == RG_VSYNC) && (q.cnt == '0);
    assign vse_line      = q.vse;
    assign last_line     = end_of_region && !nxt_found;
endmodule

// File: rtl/dsivs_steps.sv
module dsivs_steps
    import dsivs_pkg::*;
(
    input  step_e      cur,
    input  region_e    region,
    input  logic [1:0] cfg_mode,
    input  logic       cfg_vb_hse,
    input  logic       cfg_hsa_off,
    input  logic       cfg_hbp_off,
    input  logic       cfg_hfp_off,
    input  logic       cfg_eot_off,
    input  logic       null_nz,
    output logic       has_next,
    output step_e      nxt
);
    logic                 act;
    logic                 pulse;
    logic                 burst;
    logic [NUM_STEPS-1:0] en;

    assign act   = (region == RG_VACT);
    assign pulse = (cfg_mode == MD_NB_PULSE);
    assign burst = (cfg_mode == MD_B_EVENT) || (cfg_mode == MD_BURST);

    always_comb begin
        en              = '0;
        en[ST_START]    = 1'b1;
        en[ST_BLK_HSE]  = !act && cfg_vb_hse;
        en[ST_HSA]      = act && pulse && !cfg_hsa_off;
        en[ST_HSE]      = act && pulse;
        en[ST_HBP]      = act && !cfg_hbp_off;
        en[ST_PIX]      = act;
        en[ST_NULL]     = act && !burst && null_nz;
        en[ST_HFP]      = act && !cfg_hfp_off;
        en[ST_EOT]      = !cfg_eot_off;
    end

    always_comb begin
        has_next = 1'b0;
        nxt      = ST_EOT;
        for (int i = 0; i < NUM_STEPS; i++) begin
            if (!has_next && (i > int'(cur)) && en[i]) begin
                has_next = 1'b1;
                nxt      = step_e'(4'(i));
            end
        end
    end
endmodule

// File: rtl/dsivs_desc.sv
module dsivs_desc
    import dsivs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  step_e             step,
    input  logic              first_vs_line,
    input  logic              vse_line,
    input  logic [LEN_W-1:0]  cfg_hsa_len,
    input  logic [LEN_W-1:0]  cfg_hbp_len,
    input  logic [LEN_W-1:0]  cfg_hfp_len,
    input  logic [LEN_W-1:0]  cfg_act_len,
    input  logic [LEN_W-1:0]  cfg_null_len,
    input  logic [5:0]        cfg_pix_dt,
    output logic [5:0]        dt,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        dt  = DT_EOT;
        len = '0;
        unique case (step)
            ST_START: begin
                if (first_vs_line)  dt = DT_VSS;
                else if (vse_line)  dt = DT_VSE;
                else                dt = DT_HSS;
            end
            ST_BLK_HSE, ST_HSE: dt = DT_HSE;
            ST_HSA: begin dt = DT_BLANK; len = cfg_hsa_len;  end
            ST_HBP: begin dt = DT_BLANK; len = cfg_hbp_len;  end
            ST_HFP: begin dt = DT_BLANK; len = cfg_hfp_len;  end
            ST_PIX: begin dt = cfg_pix_dt; len = cfg_act_len; end
            ST_NULL: begin dt = DT_NULL; len = cfg_null_len; end
            default: dt = DT_EOT;
        endcase
    end
endmodule

// File: rtl/dsivs_seq.sv
module dsivs_seq
    import dsivs_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        cfg_vc,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_auto_vert,
    input  logic              cfg_vb_hse,
    input  logic              cfg_hsa_off,
    input  logic              cfg_hbp_off,
    input  logic              cfg_hfp_off,
    input  logic              cfg_eot_off,
    input  logic [LINE_W-1:0] cfg_vsa,
    input  logic [LINE_W-1:0] cfg_vbp,
    input  logic [LINE_W-1:0] cfg_vact,
    input  logic [LINE_W-1:0] cfg_vfp,
    input  logic [LEN_W-1:0]  cfg_hsa_len,
    input  logic [LEN_W-1:0]  cfg_hbp_len,
    input  logic [LEN_W-1:0]  cfg_hfp_len,
    input  logic [LEN_W-1:0]  cfg_act_len,
    input  logic [LEN_W-1:0]  cfg_null_len,
    input  logic [5:0]        cfg_pix_dt,
    input  logic              pkt_ready,
    output logic              pkt_valid,
    output logic [5:0]        pkt_dt,
    output logic [1:0]        pkt_vc,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              frame_done
);
    typedef struct packed {
        phase_e             phase;
        step_e              step;
        logic               valid;
        logic [5:0]         dt;
        logic [1:0]         vc;
        logic [LEN_W-1:0]   len;
        logic               done;
    } seq_state_t;

    seq_state_t q, d;

    logic              frame_start, line_adv;
    region_e           region;
    logic              first_vs_line, vse_line, last_line;
    logic              has_next;
    step_e             nxt_step, sel_step;
    logic [5:0]        sel_dt;
    logic [LEN_W-1:0]  sel_len;

    dsivs_vert #(.LINE_W(LINE_W)) vert_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .line_adv      (line_adv),
        .cfg_auto_vert (cfg_auto_vert),
        .cfg_vsa       (cfg_vsa),
        .cfg_vbp       (cfg_vbp),
        .cfg_vact      (cfg_vact),
        .cfg_vfp       (cfg_vfp),
        .region        (region),
        .first_vs_line (first_vs_line),
        .vse_line      (vse_line),
        .last_line     (last_line)
    );

    dsivs_steps steps_i (
        .cur         (q.step),
        .region      (region),
        .cfg_mode    (cfg_mode),
        .cfg_vb_hse  (cfg_vb_hse),
        .cfg_hsa_off (cfg_hsa_off),
        .cfg_hbp_off (cfg_hbp_off),
        .cfg_hfp_off (cfg_hfp_off),
        .cfg_eot_off (cfg_eot_off),
        .null_nz     (cfg_null_len != '0),
        .has_next    (has_next),
        .nxt         (nxt_step)
    );

    assign sel_step = (q.phase == PH_LOAD) ? ST_START : nxt_step;

    dsivs_desc #(.LEN_W(LEN_W)) desc_i (
        .step          (sel_step),
        .first_vs_line (first_vs_line),
        .vse_line      (vse_line),
        .cfg_hsa_len   (cfg_hsa_len),
        .cfg_hbp_len   (cfg_hbp_len),
        .cfg_hfp_len   (cfg_hfp_len),
        .cfg_act_len   (cfg_act_len),
        .cfg_null_len  (cfg_null_len),
        .cfg_pix_dt    (cfg_pix_dt),
        .dt            (sel_dt),
        .len           (sel_len)
    );

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        frame_start = 1'b0;
        line_adv    = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (en) begin
                    frame_start = 1'b1;
                    d.phase     = PH_LOAD;
                end
            end
            PH_LOAD: begin
                d.step  = ST_START;
                d.valid = 1'b1;
                d.dt    = sel_dt;
                d.len   = sel_len;
                d.vc    = cfg_vc;
                d.phase = PH_SEND;
            end
            PH_SEND: begin
                if (q.valid && pkt_ready) begin
                    if (has_next) begin
                        d.step = nxt_step;
                        d.dt   = sel_dt;
                        d.len  = sel_len;
                        d.vc   = cfg_vc;
                    end else begin
                        d.valid  = 1'b0;
                        line_adv = 1'b1;
                        if (last_line) begin
                            d.phase = PH_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.phase = PH_LOAD;
                        end
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, step: ST_START, valid: 1'b0, dt: '0,
                   vc: '0, len: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pkt_valid  = q.valid;
    assign pkt_dt     = q.dt;
    assign pkt_vc     = q.vc;
    assign pkt_len    = q.len;
    assign frame_done = q.done;
endmodule

// File: rtl/dsivs_seq_chk.sv
module dsivs_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_vc,
    input logic [1:0]       cfg_mode,
    input logic             cfg_auto_vert,
    input logic             cfg_eot_off,
    input logic             pkt_ready,
    input logic             pkt_valid,
    input logic [5:0]       pkt_dt,
    input logic [1:0]       pkt_vc,
    input logic [LEN_W-1:0] pkt_len,
    input logic             frame_done
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dt)
                                    && $stable(pkt_len) && $stable(pkt_vc));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !pkt_valid);

    p_vc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_vc == cfg_vc);

    p_no_null_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && cfg_mode[0] |-> pkt_dt != 6'h09);

    p_no_eot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && cfg_eot_off |-> pkt_dt != 6'h08);

    p_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && cfg_auto_vert |-> (pkt_dt != 6'h01) && (pkt_dt != 6'h11));
endmodule

bind dsivs_seq dsivs_seq_chk #(.LEN_W(LEN_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_vc        (cfg_vc),
    .cfg_mode      (cfg_mode),
    .cfg_auto_vert (cfg_auto_vert),
    .cfg_eot_off   (cfg_eot_off),
    .pkt_ready     (pkt_ready),
    .pkt_valid     (pkt_valid),
    .pkt_dt        (pkt_dt),
    .pkt_vc        (pkt_vc),
    .pkt_len       (pkt_len),
    .frame_done    (frame_done)
);

// File: tb/dsivs_seq_tb_top.sv
module dsivs_seq_tb_top;
    localparam int LINE_W = 12;
    localparam int LEN_W  = 16;
    localparam int MAXQ   = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [1:0]        cfg_vc = 2'd0;
    logic [1:0]        cfg_mode = 2'd0;
    logic              cfg_auto_vert = 1'b0;
    logic              cfg_vb_hse = 1'b0;
    logic              cfg_hsa_off = 1'b0;
    logic              cfg_hbp_off = 1'b0;
    logic              cfg_hfp_off = 1'b0;
    logic              cfg_eot_off = 1'b0;
    logic [LINE_W-1:0] cfg_vsa = '0;
    logic [LINE_W-1:0] cfg_vbp = '0;
    logic [LINE_W-1:0] cfg_vact = 12'd1;
    logic [LINE_W-1:0] cfg_vfp = '0;
    logic [LEN_W-1:0]  cfg_hsa_len = 16'd3;
    logic [LEN_W-1:0]  cfg_hbp_len = 16'd4;
    logic [LEN_W-1:0]  cfg_hfp_len = 16'd6;
    logic [LEN_W-1:0]  cfg_act_len = 16'd12;
    logic [LEN_W-1:0]  cfg_null_len = 16'd5;
    logic [5:0]        cfg_pix_dt = 6'h3e;
    logic              pkt_ready = 1'b0;
    logic              pkt_valid;
    logic [5:0]        pkt_dt;
    logic [1:0]        pkt_vc;
    logic [LEN_W-1:0]  pkt_len;
    logic              frame_done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hace1;

    logic [5:0]       exp_dt  [MAXQ];
    logic [LEN_W-1:0] exp_len [MAXQ];
    string            exp_req [MAXQ];
    int               exp_n;

    always #4 clk = ~clk;

    dsivs_seq #(.LINE_W(LINE_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_vc(cfg_vc), .cfg_mode(cfg_mode),
        .cfg_auto_vert(cfg_auto_vert), .cfg_vb_hse(cfg_vb_hse),
        .cfg_hsa_off(cfg_hsa_off), .cfg_hbp_off(cfg_hbp_off),
        .cfg_hfp_off(cfg_hfp_off), .cfg_eot_off(cfg_eot_off),
        .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .cfg_hsa_len(cfg_hsa_len), .cfg_hbp_len(cfg_hbp_len),
        .cfg_hfp_len(cfg_hfp_len), .cfg_act_len(cfg_act_len),
        .cfg_null_len(cfg_null_len), .cfg_pix_dt(cfg_pix_dt),
        .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_dt(pkt_dt),
        .pkt_vc(pkt_vc), .pkt_len(pkt_len), .frame_done(frame_done)
    );

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
            summary_and_end();
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic push(input logic [5:0] dt, input logic [LEN_W-1:0] len, input string req);
        if (exp_n < MAXQ) begin
            exp_dt[exp_n]  = dt;
            exp_len[exp_n] = len;
            exp_req[exp_n] = req;
            exp_n = exp_n + 1;
        end
    endtask

    // expected sequence built from the requirements
    task automatic build_expected();
        int   counts [4];
        logic vse_pend;
        counts[0] = int'(cfg_vsa);
        counts[1] = int'(cfg_vbp);
        counts[2] = int'(cfg_vact);
        counts[3] = int'(cfg_vfp);
        exp_n    = 0;
        vse_pend = 1'b0;
        for (int rg = 0; rg < 4; rg++) begin
            if (cfg_auto_vert && rg < 2) continue;  // R9
            for (int ln = 0; ln < counts[rg]; ln++) begin
                if (rg == 0 && ln == 0)  push(6'h01, '0, "R3");
                else if (vse_pend)        push(6'h11, '0, "R3");
                else                      push(6'h21, '0, "R3");
                if (rg != 2) begin
                    if (cfg_vb_hse) push(6'h31, '0, "R4");
                end else begin
                    if (cfg_mode == 2'd2) begin
                        if (!cfg_hsa_off) push(6'h19, cfg_hsa_len, "R6");
                        push(6'h31, '0, "R5");
                    end
                    if (!cfg_hbp_off) push(6'h19, cfg_hbp_len, "R6");
                    push(cfg_pix_dt, cfg_act_len, "R5");
                    if (!cfg_mode[0] && cfg_null_len != 0) push(6'h09, cfg_null_len, "R7");
                    if (!cfg_hfp_off) push(6'h19, cfg_hfp_len, "R6");
                end
                if (!cfg_eot_off) push(6'h08, '0, "R8");
                vse_pend = (rg == 0) && (ln == counts[rg] - 1);
            end
        end
    endtask

    task automatic run_frame(input int stall_idx);
        int   idx = 0;
        bit   done_seen = 0;
        bit   stalled = 0;
        logic [5:0] held_dt;
        build_expected();
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        for (int c = 0; c < 3000 && !done_seen; c++) begin
            if (frame_done) begin
                done_seen = 1;
                check("R12 frame end after last descriptor", idx == exp_n, idx, exp_n);
                check("R2 R9 descriptor count", idx == exp_n, idx, exp_n);
                pkt_ready = 1'b0;
                break;
            end
            if (pkt_valid && idx == stall_idx && !stalled) begin
                stalled = 1;
                held_dt = pkt_dt;
                pkt_ready = 1'b0;
                repeat (6) @(negedge clk);
                check("R11 valid held during stall", pkt_valid, pkt_valid, 1);
                check("R11 data type held during stall", pkt_dt == held_dt, pkt_dt, held_dt);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pkt_ready = (lfsr[1:0] != 2'b00);
            if (pkt_valid && pkt_ready) begin
                if (idx >= exp_n) begin
                    check("R2 extra descriptor", 1'b0, pkt_dt, 0);
                end else begin
                    check(exp_req[idx], pkt_dt == exp_dt[idx], pkt_dt, exp_dt[idx]);
                    check({exp_req[idx], " length"}, pkt_len == exp_len[idx],
                          pkt_len, exp_len[idx]);
                    check("R10 virtual channel", pkt_vc == cfg_vc, pkt_vc, cfg_vc);
                end
                idx = idx + 1;
            end
            @(negedge clk);
        end
        if (!done_seen) check("R12 frame end missing", 1'b0, idx, exp_n);
        @(negedge clk);
        check("R12 done lasts one cycle", !frame_done, frame_done, 0);
        repeat (3) @(negedge clk);
        check("R12 idle after frame", !pkt_valid, pkt_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid low", !pkt_valid, pkt_valid, 0);
        check("R1 reset done low", !frame_done, frame_done, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 no output without en", !pkt_valid && !frame_done, pkt_valid, 0);

        // forced stall on the fifth descriptor
        cfg_vsa = 12'd1; cfg_vbp = 12'd1; cfg_vact = 12'd2; cfg_vfp = 12'd1;
        run_frame(4);

        // vertical sweep, including zero-count regions and auto vertical mode
        for (int a = 0; a < 2; a++)
            for (int vs = 0; vs < 3; vs++)
                for (int vb = 0; vb < 2; vb++)
                    for (int va = 1; va < 3; va++)
                        for (int vf = 0; vf < 2; vf++) begin
                            cfg_auto_vert = a[0];
                            cfg_vsa  = 12'(vs);
                            cfg_vbp  = 12'(vb);
                            cfg_vact = 12'(va);
                            cfg_vfp  = 12'(vf);
                            cfg_vc   = 2'(vs + va);
                            cfg_mode = 2'(vb + 2 * vf);
                            run_frame(-1);
                        end

        // horizontal sweep over modes, region disables, sync-end option
        cfg_auto_vert = 1'b0;
        cfg_vsa = 12'd2; cfg_vbp = 12'd1; cfg_vact = 12'd1; cfg_vfp = 12'd1;
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 16; f++)
                for (int h = 0; h < 2; h++) begin
                    cfg_mode     = 2'(m);
                    cfg_hsa_off  = f[0];
                    cfg_hbp_off  = f[1];
                    cfg_hfp_off  = f[2];
                    cfg_eot_off  = f[3];
                    cfg_vb_hse   = h[0];
                    cfg_null_len = (f[0] ^ h[0]) ? 16'd0 : 16'd5;
                    cfg_vc       = 2'(m + f);
                    run_frame(-1);
                end
        summary_and_end();
    end
endmodule